// File: doc/BRIEF.md
# External Interrupt Condition Detector

This block turns nine asynchronous external interrupt pins into interrupt request flags for the on-chip interrupt controller. Each pin has its own trigger condition: a high level, a low level, a falling edge or a rising edge. A separate per-pin enable makes the pin trigger on both edges, whatever single condition is selected. Every pin first passes through a two-flop synchroniser. It then passes through an optional digital noise filter, which can be used with any trigger condition.

Edge conditions latch a request that stays set until the per-pin clear input removes it. Level conditions drive the request directly from the filtered pin level. When the filter is enabled, a new pin level is accepted only after it has held for a programmable number of sample clocks. Shorter glitches therefore produce neither an edge nor a level request. Prioritisation, vectoring and pin multiplexing are handled elsewhere.

Top module: `ext_irq_detect`

## Requirements
- R1: The pins are independent. Stimulus, configuration or clear on one pin never changes the request of another pin.
- R2: With the filter off, a pin change reaches a level request 3 clock edges after it is applied, and an edge request 4 clock edges after it is applied. The path is two synchroniser flops, one filtered-level register and one edge register.
- R3: When both-edge detection is off, the 2-bit condition code of pin i sits at bits [2i+1:2i] of `cond_sel`. The codes are: 2'b00 low level, 2'b01 high level, 2'b10 falling edge, 2'b11 rising edge. An edge of the opposite direction sets nothing.
- R4: When `both_edge[i]` is 1, pin i latches a request on rising and on falling edges, whatever its condition code.
- R5: In a level condition, the request is high exactly while the filtered level equals the selected level. The clear input has no effect on it.
- R6: In an edge condition, the request stays set until `clr[i]` is high at a clock edge. If a new edge and the clear arrive at the same edge, the request stays set.
- R7: With `filt_en[i]` set, a new level is accepted only after the synchronised pin has differed from the accepted level for `filt_len`+1 consecutive clocks. A pulse of `filt_len` clocks or fewer is fully rejected. An accepted change arrives `filt_len` cycles later than in R2.
- R8: The filter applies under level conditions as well as edge conditions.
- R9: Reset clears all latched requests and sets every filtered level to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | N_PINS | Raw asynchronous pin levels |
| cond_sel | input | 2*N_PINS | Per-pin condition code, two bits per pin |
| both_edge | input | N_PINS | Per-pin both-edge enable |
| filt_en | input | N_PINS | Per-pin noise filter enable |
| filt_len | input | CNT_W | Filter length in clocks, shared by all pins |
| clr | input | N_PINS | Per-pin request clear |
| irq | output | N_PINS | Per-pin interrupt request |

## Verification
With the filter off, a level request is due 3 clock edges after a pin change and an edge request is due at the 4th edge. With the filter on, each result arrives `filt_len` edges later. The bench drives inputs and samples outputs a quarter period after a rising edge. For each timing case it checks that the request is still absent one edge before it is due and present at the due edge. Glitch rejection is checked by sampling the request on every cycle of a pulse plus several cycles after it. The simultaneous set-and-clear case raises the clear exactly in the cycle whose closing edge latches the edge.

// File: rtl/ext_irq_pkg.sv
// Shared types for the external interrupt detector.
package ext_irq_pkg;
    // Per-pin trigger condition; bit 1 set means an edge condition.
    typedef enum logic [1:0] {
        COND_LOW  = 2'b00,
        COND_HIGH = 2'b01,
        COND_FALL = 2'b10,
        COND_RISE = 2'b11
    } cond_e;
endpackage

// File: rtl/eirq_sync.sv
// Two-flop synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherence is implied.
module eirq_sync #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    // Two register stages toward the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

    // R2: output is the input delayed by exactly two clocks
    a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/eirq_filter.sv
// Stability filter for one synchronised pin. A differing level must persist
// for len+1 consecutive clocks before it is accepted. When disabled, the
// output follows the input one clock later. Assumes a synchronous input.
module eirq_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s,
    input  logic             en,
    input  logic [CNT_W-1:0] len,
    output logic             lvl
);
    logic [CNT_W-1:0] cnt;

    // Count cycles of disagreement and accept the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= 1'b0;
            cnt <= '0;
        end else if (!en) begin
            lvl <= s;
            cnt <= '0;
        end else if (s == lvl) begin
            cnt <= '0;
        end else if (cnt >= len) begin
            lvl <= s;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: an accepted level always equals the previous sampled input
    a_r7_accept_matches: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl) |-> (lvl == $past(s)));
    // R7: with a steady length the counter never runs past it
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(len) |-> (cnt <= len));
endmodule

// File: rtl/eirq_detect.sv
// Condition detector for one filtered pin. Edge conditions latch a sticky
// request that is cleared by clr; a new edge wins over a simultaneous clear.
// Level conditions drive the request straight from the filtered level.
module eirq_detect
    import ext_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lvl,
    input  cond_e cond,
    input  logic  both,
    input  logic  clr,
    output logic  irq
);
    logic prev;
    logic flag;
    logic rise;
    logic fall;
    logic hit;
    logic level_mode;

    // Decode which edge, if any, is selected and seen this cycle.
    always_comb begin
        rise = lvl & ~prev;
        fall = ~lvl & prev;
        if (both) begin
            hit = rise | fall;
        end else begin
            case (cond)
                COND_RISE: hit = rise;
                COND_FALL: hit = fall;
                default:   hit = 1'b0;
            endcase
        end
        level_mode = !both && !cond[1];
        irq = level_mode ? (lvl == cond[0]) : flag;
    end

    // Remember the last level and keep the sticky request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            flag <= 1'b0;
        end else begin
            prev <= lvl;
            flag <= hit | (flag & ~clr);
        end
    end

    // R6: the sticky request only drops after a clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr));
    // R6: the request only rises when the filtered level moved
    a_r6_set_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(lvl != prev));
endmodule

// File: rtl/ext_irq_detect.sv
// External interrupt detector top: one shared synchroniser, then one filter
// and one condition detector per pin. Assumes pins are asynchronous and
// that configuration is quasi-static.
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int N_PINS = 9,
    parameter int CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_PINS-1:0]     pin_in,
    input  logic [2*N_PINS-1:0]   cond_sel,
    input  logic [N_PINS-1:0]     both_edge,
    input  logic [N_PINS-1:0]     filt_en,
    input  logic [CNT_W-1:0]      filt_len,
    input  logic [N_PINS-1:0]     clr,
    output logic [N_PINS-1:0]     irq
);
    localparam int SEL_W = 2;

    logic [N_PINS-1:0] pin_s;
    logic [N_PINS-1:0] pin_f;

    eirq_sync #(.WIDTH(N_PINS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    for (genvar gi = 0; gi < N_PINS; gi++) begin : g_pin
        eirq_filter #(.CNT_W(CNT_W)) i_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .s     (pin_s[gi]),
            .en    (filt_en[gi]),
            .len   (filt_len),
            .lvl   (pin_f[gi])
        );

        eirq_detect i_det (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (pin_f[gi]),
            .cond  (cond_e'(cond_sel[SEL_W*gi +: SEL_W])),
            .both  (both_edge[gi]),
            .clr   (clr[gi]),
            .irq   (irq[gi])
        );
    end
endmodule

// File: tb/test_ext_irq_detect.sv
module test_ext_irq_detect;
    localparam int CLK_PERIOD = 10;
    localparam int N = 9;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_in = '0;
    logic [2*N-1:0] cond_sel = {N{2'b11}};
    logic [N-1:0]  both_edge = '0;
    logic [N-1:0]  filt_en = '0;
    logic [CW-1:0] filt_len = '0;
    logic [N-1:0]  clr = '0;
    logic [N-1:0]  irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_detect #(.N_PINS(N), .CNT_W(CW)) i_ext_irq_detect (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cond_sel(cond_sel),
        .both_edge(both_edge), .filt_en(filt_en), .filt_len(filt_len),
        .clr(clr), .irq(irq)
    );

    // Advance n rising edges, landing a quarter period after the last.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic set_cond(input int p, input logic [1:0] c);
        cond_sel[2*p +: 2] = c;
    endtask

    task automatic pulse_clr(input int p);
        clr[p] = 1'b1;
        step(1);
        clr[p] = 1'b0;
    endtask

    // R9: after reset no request with every pin on rising edge
    task automatic t_reset();
        check("R9 reset requests low", irq, '0);
    endtask

    // R2 R3 R1: rising-edge timing on pin 0, others untouched
    task automatic t_rise_timing();
        pin_in[0] = 1'b1;
        step(3);
        check("R2 edge not before 4th edge", irq, '0);
        step(1);
        check("R2 R3 rising edge latched, R1 others idle", irq, 9'b000000001);
    endtask

    // R6 R3: sticky through a falling edge, cleared by clr, fall ignored
    task automatic t_sticky();
        pin_in[0] = 1'b0;
        step(6);
        check("R6 request sticky after pin falls", irq[0], 1'b1);
        pulse_clr(0);
        check("R6 clear drops request", irq[0], 1'b0);
        step(4);
        check("R3 falling edge ignored in rising mode", irq[0], 1'b0);
    endtask

    // R3: falling condition on pin 1
    task automatic t_fall();
        set_cond(1, 2'b10);
        pin_in[1] = 1'b1;
        step(6);
        check("R3 rising edge ignored in falling mode", irq[1], 1'b0);
        pin_in[1] = 1'b0;
        step(3);
        check("R2 falling not before 4th edge", irq[1], 1'b0);
        step(1);
        check("R3 falling edge latched", irq[1], 1'b1);
        pulse_clr(1);
    endtask

    // R4: both-edge enable overrides a low-level code on pin 2
    task automatic t_both();
        set_cond(2, 2'b00);
        both_edge[2] = 1'b1;
        step(1);
        check("R4 no request while both-edge idle", irq[2], 1'b0);
        pin_in[2] = 1'b1;
        step(4);
        check("R4 rising edge latched in both mode", irq[2], 1'b1);
        pulse_clr(2);
        check("R4 cleared", irq[2], 1'b0);
        pin_in[2] = 1'b0;
        step(4);
        check("R4 falling edge latched in both mode", irq[2], 1'b1);
        pulse_clr(2);
    endtask

    // R5: level conditions on pins 3 (high) and 4 (low)
    task automatic t_level();
        set_cond(3, 2'b01);
        set_cond(4, 2'b00);
        step(1);
        check("R5 low level active on idle pin 4", irq[4], 1'b1);
        pin_in[3] = 1'b1;
        pin_in[4] = 1'b1;
        step(2);
        check("R2 level not before 3rd edge", irq[4:3], 2'b10);
        step(1);
        check("R5 high level asserted, low level released", irq[4:3], 2'b01);
        clr[3] = 1'b1;
        step(2);
        check("R5 clear has no effect on level request", irq[3], 1'b1);
        clr[3] = 1'b0;
        pin_in[3] = 1'b0;
        pin_in[4] = 1'b0;
        step(3);
        check("R5 level requests follow pin back", irq[4:3], 2'b10);
        set_cond(4, 2'b11);
        step(1);
    endtask

    // R6: new edge wins over a clear at the same edge, on pin 5
    task automatic t_set_wins();
        pin_in[5] = 1'b1;
        step(3);
        clr[5] = 1'b1;
        step(1);
        clr[5] = 1'b0;
        check("R6 set wins over simultaneous clear", irq[5], 1'b1);
        pulse_clr(5);
        check("R6 later clear works", irq[5], 1'b0);
    endtask

    // R7: filtered rising edge on pin 6 with length 4
    task automatic t_filter_edge();
        logic seen;
        filt_len = 8'd4;
        filt_en[6] = 1'b1;
        step(1);
        seen = 1'b0;
        pin_in[6] = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step(1);
            seen |= irq[6];
        end
        pin_in[6] = 1'b0;
        for (int k = 0; k < 10; k++) begin
            step(1);
            seen |= irq[6];
        end
        check("R7 pulse of filt_len clocks rejected", seen, 1'b0);
        pin_in[6] = 1'b1;
        step(7);
        check("R7 filtered edge not before L+4", irq[6], 1'b0);
        step(1);
        check("R7 filtered edge latched at L+4", irq[6], 1'b1);
        pulse_clr(6);
    endtask

    // R8: filter under a high-level condition on pin 7 with length 2
    task automatic t_filter_level();
        logic seen;
        filt_len = 8'd2;
        filt_en[7] = 1'b1;
        set_cond(7, 2'b01);
        step(1);
        seen = 1'b0;
        pin_in[7] = 1'b1;
        for (int k = 0; k < 2; k++) begin
            step(1);
            seen |= irq[7];
        end
        pin_in[7] = 1'b0;
        for (int k = 0; k < 8; k++) begin
            step(1);
            seen |= irq[7];
        end
        check("R8 short pulse rejected in level mode", seen, 1'b0);
        pin_in[7] = 1'b1;
        step(4);
        check("R8 filtered level not before L+3", irq[7], 1'b0);
        step(1);
        check("R8 filtered level asserted at L+3", irq[7], 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_rise_timing();
        t_sticky();
        t_fall();
        t_both();
        t_level();
        t_set_wins();
        t_filter_edge();
        t_filter_level();
        check("R1 untouched pin 8 stays idle", irq[8], 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule